// File: doc/BRIEF.md
# Linear Image Sensor Line Timing Generator

This block produces every timing waveform a 2048-pixel linear image sensor needs for line readout. A phase counter divides the system clock down to the pixel rate, and a line-level state machine steps through charge transfer, a guard gap, pixel shifting and an end-of-line gap. During shifting it drives two complementary shift clocks with a dead cycle between them and a per-pixel reset pulse. It also issues two sample strobes per pixel for correlated double sampling. The first strobe catches the reference level at the start of the pixel period. The second catches the video level, which is negative-going and lies below that reference, near the end of the period.

Control logic issues a single-cycle start together with the number of lines to capture. A four-frame capture is four lines, or 8192 pixels. The block runs the lines back to back, then drops busy and pulses done. The downstream converter interface uses the pixel-valid strobe, the pixel index and the line-start flag to frame the data. Every output comes from a register, one system clock after the internal state that defines it.

Top module: `ccd_line_timer`

## Requirements
- R1: After reset, and whenever the block is idle, every output is low and pix_idx_o is zero.
- R2: A capture begins only when start_i is high and num_lines_i is nonzero while the block is idle. A start with num_lines_i equal to zero is ignored. A start while busy is ignored and leaves the number of lines being captured unchanged.
- R3: A pixel period lasts PIX_DIV system clocks. With the default of 5, this gives 10 MHz from a 50 MHz clock. Each line shifts out exactly N_PIX pixels, and pix_valid_o is high for one system clock per pixel.
- R4: Each line opens with tg_o high for XFER_PIX pixel periods. GUARD_PIX pixel periods follow (at least two), in which tg_o and both shift clocks are low, before the first shift clock.
- R5: During shifting, phase p of the pixel period counts from 0. sh1_o is high for p from 0 to PIX_DIV/2-2. sh2_o is high for p from PIX_DIV/2 to PIX_DIV-2. The two are never high together, and each hand-over from one to the other has at least one system clock in which both are low.
- R6: Within each shifted pixel, rst_pulse_o is high at phase 0, samp_ref_o at phase 1 and samp_sig_o at phase PIX_DIV-2. The reference strobe therefore always precedes the signal strobe. pix_valid_o coincides with samp_sig_o. None of these strobes occurs outside shifting.
- R7: line_start_o is high for exactly the PIX_DIV system clocks of pixel 0 of each line. pix_idx_o carries the pixel number, 0 to N_PIX-1, during shifting.
- R8: Each line ends with END_PIX idle pixel periods, and the next line starts immediately after them. After num_lines_i lines, busy_o falls and done_o is high for one system clock. The total pixel-valid count equals num_lines_i times N_PIX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture request pulse |
| num_lines_i | input | LINES_W | Number of lines to capture |
| tg_o | output | 1 | Transfer gate drive |
| sh1_o | output | 1 | Shift clock, first phase |
| sh2_o | output | 1 | Shift clock, second phase |
| rst_pulse_o | output | 1 | Sensor output-node reset pulse |
| samp_ref_o | output | 1 | Reference-level sample strobe |
| samp_sig_o | output | 1 | Video-level sample strobe |
| pix_valid_o | output | 1 | Pixel data valid for converter |
| pix_idx_o | output | $clog2(N_PIX) | Index of the current pixel |
| line_start_o | output | 1 | First pixel of a line |
| busy_o | output | 1 | Capture in progress |
| done_o | output | 1 | Capture finished pulse |

## Verification
The assertions watch properties that must hold in every cycle. The two shift clocks never overlap and always have a dead cycle at each hand-over. The reset and sample strobes stay mutually exclusive and appear only while busy. The transfer gate never coincides with a shift clock. done_o is a single-cycle pulse seen only while idle, and an idle block drives nothing.

Only the bench scenarios can show the counts and placements. These are the exact pixel period, the 2048 pixels per line, the transfer and guard lengths, and the line-start window. They also include the number of lines actually run and the rejection of a start that is zero-length or arrives mid-capture. The bench checks these by comparing every output in every cycle against a timeline computed from the requirements.

// File: rtl/ccd_timer_pkg.sv
package ccd_timer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_END   = 2'd3
  } ln_state_t;
endpackage

// File: rtl/ccd_pix_div.sv
module ccd_pix_div #(
  parameter int PIX_DIV = 5,
  parameter int PH_W    = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  output logic [PH_W-1:0] ph_o,
  output logic            tick_o
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PIX_DIV - 1);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ph_q <= '0;
    else if (!run_i)        ph_q <= '0;
    else if (ph_q == PH_LAST) ph_q <= '0;
    else                    ph_q <= ph_q + 1'b1;
  end

  assign ph_o   = ph_q;
  assign tick_o = run_i && (ph_q == PH_LAST);
endmodule

// File: rtl/ccd_line_fsm.sv
module ccd_line_fsm
  import ccd_timer_pkg::*;
#(
  parameter int N_PIX     = 2048,
  parameter int XFER_PIX  = 2,
  parameter int GUARD_PIX = 2,
  parameter int END_PIX   = 2,
  parameter int LINES_W   = 16,
  parameter int CNT_W     = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [LINES_W-1:0] num_lines_i,
  input  logic               tick_i,
  output ln_state_t          state_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               done_o
);
  localparam logic [CNT_W-1:0] XFER_LAST  = CNT_W'(XFER_PIX + GUARD_PIX - 1);
  localparam logic [CNT_W-1:0] SHIFT_LAST = CNT_W'(N_PIX - 1);
  localparam logic [CNT_W-1:0] END_LAST   = CNT_W'(END_PIX - 1);

  ln_state_t          state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [LINES_W-1:0] left_q, left_d;
  logic               done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    left_d  = left_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i && (num_lines_i != '0)) begin
          state_d = ST_XFER;
          cnt_d   = '0;
          left_d  = num_lines_i;
        end
      end
      ST_XFER: if (tick_i) begin
        if (cnt_q == XFER_LAST) begin
          state_d = ST_SHIFT;
          cnt_d   = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_SHIFT: if (tick_i) begin
        if (cnt_q == SHIFT_LAST) begin
          state_d = ST_END;
          cnt_d   = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_END: if (tick_i) begin
        if (cnt_q == END_LAST) begin
          cnt_d  = '0;
          left_d = left_q - 1'b1;
          if (left_q == LINES_W'(1)) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else state_d = ST_XFER;
        end else cnt_d = cnt_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      left_q  <= '0;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      left_q  <= left_d;
      done_o  <= done_d;
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/ccd_wave_decode.sv
module ccd_wave_decode
  import ccd_timer_pkg::*;
#(
  parameter int PIX_DIV  = 5,
  parameter int XFER_PIX = 2,
  parameter int PH_W     = 3,
  parameter int CNT_W    = 11,
  parameter int IDX_W    = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ln_state_t        state_i,
  input  logic [PH_W-1:0]  ph_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             done_i,
  output logic             tg_o,
  output logic             sh1_o,
  output logic             sh2_o,
  output logic             rst_pulse_o,
  output logic             samp_ref_o,
  output logic             samp_sig_o,
  output logic             pix_valid_o,
  output logic [IDX_W-1:0] pix_idx_o,
  output logic             line_start_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int              HALF    = PIX_DIV / 2;
  localparam logic [PH_W-1:0] SH1_END = PH_W'(HALF - 2);
  localparam logic [PH_W-1:0] SH2_BEG = PH_W'(HALF);
  localparam logic [PH_W-1:0] SH2_END = PH_W'(PIX_DIV - 2);
  localparam logic [PH_W-1:0] REF_PH  = PH_W'(1);
  localparam logic [PH_W-1:0] SIG_PH  = PH_W'(PIX_DIV - 2);

  logic shifting, sig_d;
  assign shifting = (state_i == ST_SHIFT);
  assign sig_d    = shifting && (ph_i == SIG_PH);

  // registered outputs: no decode glitches reach the sensor
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tg_o         <= 1'b0;
      sh1_o        <= 1'b0;
      sh2_o        <= 1'b0;
      rst_pulse_o  <= 1'b0;
      samp_ref_o   <= 1'b0;
      samp_sig_o   <= 1'b0;
      pix_valid_o  <= 1'b0;
      pix_idx_o    <= '0;
      line_start_o <= 1'b0;
      busy_o       <= 1'b0;
      done_o       <= 1'b0;
    end else begin
      tg_o         <= (state_i == ST_XFER) && (cnt_i < CNT_W'(XFER_PIX));
      sh1_o        <= shifting && (ph_i <= SH1_END);
      sh2_o        <= shifting && (ph_i >= SH2_BEG) && (ph_i <= SH2_END);
      rst_pulse_o  <= shifting && (ph_i == '0);
      samp_ref_o   <= shifting && (ph_i == REF_PH);
      samp_sig_o   <= sig_d;
      pix_valid_o  <= sig_d;
      pix_idx_o    <= shifting ? IDX_W'(cnt_i) : '0;
      line_start_o <= shifting && (cnt_i == '0);
      busy_o       <= (state_i != ST_IDLE);
      done_o       <= done_i;
    end
  end
endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
  import ccd_timer_pkg::*;
#(
  parameter int PIX_DIV   = 5,
  parameter int N_PIX     = 2048,
  parameter int XFER_PIX  = 2,
  parameter int GUARD_PIX = 2,
  parameter int END_PIX   = 2,
  parameter int LINES_W   = 16,
  localparam int IDX_W    = $clog2(N_PIX)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [LINES_W-1:0] num_lines_i,
  output logic               tg_o,
  output logic               sh1_o,
  output logic               sh2_o,
  output logic               rst_pulse_o,
  output logic               samp_ref_o,
  output logic               samp_sig_o,
  output logic               pix_valid_o,
  output logic [IDX_W-1:0]   pix_idx_o,
  output logic               line_start_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam int PH_W  = $clog2(PIX_DIV);
  localparam int CNT_W = IDX_W;

  ln_state_t        state;
  logic [PH_W-1:0]  ph;
  logic [CNT_W-1:0] cnt;
  logic             tick, fsm_done;

  ccd_pix_div #(.PIX_DIV(PIX_DIV), .PH_W(PH_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state != ST_IDLE),
    .ph_o   (ph),
    .tick_o (tick)
  );

  ccd_line_fsm #(
    .N_PIX(N_PIX), .XFER_PIX(XFER_PIX), .GUARD_PIX(GUARD_PIX),
    .END_PIX(END_PIX), .LINES_W(LINES_W), .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .num_lines_i (num_lines_i),
    .tick_i      (tick),
    .state_o     (state),
    .cnt_o       (cnt),
    .done_o      (fsm_done)
  );

  ccd_wave_decode #(
    .PIX_DIV(PIX_DIV), .XFER_PIX(XFER_PIX), .PH_W(PH_W),
    .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_dec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .state_i      (state),
    .ph_i         (ph),
    .cnt_i        (cnt),
    .done_i       (fsm_done),
    .tg_o         (tg_o),
    .sh1_o        (sh1_o),
    .sh2_o        (sh2_o),
    .rst_pulse_o  (rst_pulse_o),
    .samp_ref_o   (samp_ref_o),
    .samp_sig_o   (samp_sig_o),
    .pix_valid_o  (pix_valid_o),
    .pix_idx_o    (pix_idx_o),
    .line_start_o (line_start_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );
endmodule

// File: rtl/ccd_line_timer_chk.sv
module ccd_line_timer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tg_o,
  input logic sh1_o,
  input logic sh2_o,
  input logic rst_pulse_o,
  input logic samp_ref_o,
  input logic samp_sig_o,
  input logic pix_valid_o,
  input logic line_start_o,
  input logic busy_o,
  input logic done_o
);
  AST_SHIFT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sh1_o && sh2_o)); // R5
  AST_SH2_DEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sh2_o) |-> !$past(sh1_o)); // R5
  AST_SH1_DEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sh1_o) |-> !$past(sh2_o)); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rst_pulse_o, samp_ref_o, samp_sig_o})); // R6
  AST_STROBE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_pulse_o || samp_ref_o || samp_sig_o || pix_valid_o) |-> busy_o); // R6
  AST_REF_BEFORE_SIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_ref_o |=> !samp_sig_o); // R6
  AST_TG_NO_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tg_o |-> !(sh1_o || sh2_o || line_start_o)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(tg_o || sh1_o || sh2_o || line_start_o)); // R1
endmodule

bind ccd_line_timer ccd_line_timer_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tg_o         (tg_o),
  .sh1_o        (sh1_o),
  .sh2_o        (sh2_o),
  .rst_pulse_o  (rst_pulse_o),
  .samp_ref_o   (samp_ref_o),
  .samp_sig_o   (samp_sig_o),
  .pix_valid_o  (pix_valid_o),
  .line_start_o (line_start_o),
  .busy_o       (busy_o),
  .done_o       (done_o)
);

// File: tb/ccd_line_timer_tb_top.sv
`timescale 1ns/1ps
module ccd_line_timer_tb_top;
  localparam int DIV   = 5;
  localparam int NP    = 2048;
  localparam int TGP   = 2;
  localparam int GP    = 2;
  localparam int EP    = 2;
  localparam int LW    = 16;
  localparam int IW    = $clog2(NP);
  localparam int LINE  = (TGP + GP + NP + EP) * DIV;
  localparam int HALF  = DIV / 2;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [LW-1:0] num_lines_i = '0;
  logic tg_o, sh1_o, sh2_o, rst_pulse_o, samp_ref_o, samp_sig_o;
  logic pix_valid_o, line_start_o, busy_o, done_o;
  logic [IW-1:0] pix_idx_o;

  int checks = 0, fails = 0, cycles = 0;

  always #10 clk_i = ~clk_i;

  ccd_line_timer #(.PIX_DIV(DIV), .N_PIX(NP), .XFER_PIX(TGP), .GUARD_PIX(GP),
                   .END_PIX(EP), .LINES_W(LW)) dut_i (.*);

  // bit order: tg sh1 sh2 rst ref sig valid ls busy done
  function automatic logic [9:0] exp_vec(int p, int n);
    logic [9:0] v = '0;
    if (p < 0) return v;
    if (p >= n * LINE) begin
      v[0] = (p == n * LINE);
      return v;
    end
    begin
      int o = p % LINE, pix = o / DIV, ph = o % DIV;
      v[1] = 1'b1;
      v[9] = pix < TGP;
      if (pix >= TGP + GP && pix < TGP + GP + NP) begin
        v[8] = ph <= HALF - 2;
        v[7] = ph >= HALF && ph <= DIV - 2;
        v[6] = ph == 0;
        v[5] = ph == 1;
        v[4] = ph == DIV - 2;
        v[3] = ph == DIV - 2;
        v[2] = (pix - TGP - GP) == 0;
      end
    end
    return v;
  endfunction

  function automatic int exp_idx(int p, int n);
    int o, pix;
    if (p < 0 || p >= n * LINE) return 0;
    o = p % LINE; pix = o / DIV;
    if (pix >= TGP + GP && pix < TGP + GP + NP) return pix - TGP - GP;
    return 0;
  endfunction

  function automatic string req_of(logic [9:0] d);
    if (d[9]) return "R4";
    if (d[8] | d[7]) return "R5";
    if (d[6] | d[5] | d[4]) return "R6";
    if (d[3]) return "R3";
    if (d[2]) return "R7";
    return "R8";
  endfunction

  function automatic logic [9:0] act_vec();
    return {tg_o, sh1_o, sh2_o, rst_pulse_o, samp_ref_o, samp_sig_o,
            pix_valid_o, line_start_o, busy_o, done_o};
  endfunction

  task automatic chk_vec(string tag, logic [9:0] exp);
    logic [9:0] a = act_vec();
    checks++;
    if (a !== exp) begin
      fails++;
      $display("FAIL %s %s: outputs act=%b exp=%b", tag, req_of(a ^ exp), a, exp);
    end
  endtask

  // Runs one capture, comparing every output each cycle; inj>=0 injects a busy start
  task automatic run_capture(int n, int inj);
    int vcnt = 0;
    @(negedge clk_i);
    start_i = 1'b1; num_lines_i = LW'(n);
    @(negedge clk_i);
    start_i = 1'b0; num_lines_i = '0;
    for (int p = 0; p <= n * LINE + 1; p++) begin
      @(negedge clk_i);
      start_i = 1'b0;
      chk_vec($sformatf("p=%0d", p), exp_vec(p, n));
      if (pix_valid_o) begin
        vcnt++;
        checks++;
        if (int'(pix_idx_o) != exp_idx(p, n)) begin
          fails++;
          $display("FAIL R7: pix_idx act=%0d exp=%0d", pix_idx_o, exp_idx(p, n));
        end
      end
      if (p == inj) begin
        start_i = 1'b1; num_lines_i = LW'(3); // R2: must be ignored
      end
    end
    checks++;
    if (vcnt != n * NP) begin
      fails++;
      $display("FAIL R8: valid count act=%0d exp=%0d", vcnt, n * NP);
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp<190000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0c0d_2048));
    repeat (3) @(negedge clk_i);
    chk_vec("reset R1", '0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk_vec("idle R1", '0);
    // R2: zero-length request is ignored
    start_i = 1'b1; num_lines_i = '0;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      chk_vec("zero-lines R2", '0);
    end
    // R3 R8: four-line capture, 8192 pixels
    run_capture(4, -1);
    // R2: start mid-run ignored, random inject point
    run_capture(1, 100 + int'($urandom_range(0, 9000)));
    for (int k = 0; k < 2; k++)
      run_capture(int'($urandom_range(1, 2)), int'($urandom_range(0, LINE - 1)));
    repeat (4) begin
      @(negedge clk_i);
      chk_vec("post idle R1", '0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule